// File: doc/BRIEF.md
# Time-Multiplexed Interrupt Level Driver

This block presents interrupt requests from a small set of request sources on a shared 8-bit request bus. The bus carries 32 request levels by time-multiplexing. A 2-bit slot code from the bus side names which group of eight levels the bus carries in the current cycle. Each source has a 5-bit programmable level taken from a 16-bit configuration word. A source is pending when its status flag and its enable flag are both set. While the slot code selects the group that holds that source's level, a pending source asserts one bus bit.

The block applies no priority between sources. When two pending sources share a level, both assert the same bit, and software sorts out the conflict. Contributions from the sources are combined by OR and registered, so the bus reflects the inputs sampled at the previous rising clock edge. Queue 1 is source bit 0 of the flag and enable vectors, and queue 2 is bit 1.

Top module: `irq_slot_driver`

## Requirements
- R1: While `rst_n` is low the request bus is all zeros, and it stays zero until the first rising edge after release.
- R2: The queue 1 level is `cfg[15:11]` and the queue 2 level is `cfg[10:6]`, each an unsigned binary level from 0 (00000) to 31 (11111).
- R3: The slot code selects the level group as follows: 2'b00 selects levels 0-7, 2'b01 selects 8-15, 2'b11 selects 16-23 and 2'b10 selects 24-31.
- R4: When a source with level L is pending and the slot code selects group L/8, bus bit (L mod 8) is 1.
- R5: A source contributes nothing unless both its status flag and its enable flag are 1.
- R6: A pending source drives no bus bit while the slot code selects a group other than its own.
- R7: With both sources pending, the bus is the bitwise OR of their contributions. Two sources at the same level set one single bit.
- R8: The reserved bits `cfg[5:0]` have no effect on the bus.
- R9: The bus is registered. A change on any input appears on `irq_bus` only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_sel | input | 2 | Slot code from the bus sequencer (Gray order 00, 01, 11, 10) |
| src_flag | input | 2 | Status flags; bit 0 is queue 1, bit 1 is queue 2 |
| src_en | input | 2 | Interrupt enables; bit 0 is queue 1, bit 1 is queue 2 |
| cfg | input | 16 | Level configuration word |
| irq_bus | output | 8 | Registered request bus for the current slot |

## Verification
A wrong group decode or a wrong level field shows on the bus one clock after the offending slot code is applied. It appears as a bit in the wrong slot or in the wrong position. The sweep puts every level through every slot code, so no single slot mapping can be wrong without being seen within that cycle. A lost OR term or a lost enable gate shows up in the very next registered value when both sources are active or when only one of the two flags is set. A latency fault shows up as a changed bus before the edge that should carry the new value.

// File: rtl/irq_slot_pkg.sv
package irq_slot_pkg;

  localparam int MAX_CODE_W = 8;

  // Convert a reflected-binary slot code to its plain binary group index.
  function automatic logic [MAX_CODE_W-1:0] gray_to_index(input logic [MAX_CODE_W-1:0] g);
    logic [MAX_CODE_W-1:0] b;
    b[MAX_CODE_W-1] = g[MAX_CODE_W-1];
    for (int i = MAX_CODE_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

  // Number of request levels per bus slot for a given level and slot width.
  function automatic int levels_per_slot(input int lvl_w, input int slot_w);
    return 1 << (lvl_w - slot_w);
  endfunction

endpackage

// File: rtl/irq_cfg_unpack.sv
module irq_cfg_unpack #(
  parameter int CFG_W   = 16,
  parameter int LVL_W   = 5,
  parameter int NUM_SRC = 2
) (
  input  logic [CFG_W-1:0]                cfg,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl
);
  localparam int USED_W = NUM_SRC * LVL_W;
  localparam int RES_W  = CFG_W - USED_W;

  // Fields are packed from the most significant end, source 0 first.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_field
    assign lvl[i] = cfg[CFG_W-1-i*LVL_W -: LVL_W];
  end

  // Low bits are reserved and take no part in the request path.
  if (RES_W > 0) begin : g_resv
    logic unused_resv;
    assign unused_resv = ^cfg[RES_W-1:0];
  end
endmodule

// File: rtl/irq_group_decode.sv
module irq_group_decode
  import irq_slot_pkg::*;
#(
  parameter int SLOT_W = 2
) (
  input  logic [SLOT_W-1:0]          slot_sel,
  output logic [(1<<SLOT_W)-1:0]     grp_sel
);
  localparam int NGRP = 1 << SLOT_W;

  logic [MAX_CODE_W-1:0] idx_full;
  logic [SLOT_W-1:0]     grp_idx;

  assign idx_full = gray_to_index(MAX_CODE_W'(slot_sel));
  assign grp_idx  = idx_full[SLOT_W-1:0];

  always_comb begin
    grp_sel = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (grp_idx == SLOT_W'(g)) grp_sel[g] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_src_lane.sv
module irq_src_lane #(
  parameter int LVL_W  = 5,
  parameter int SLOT_W = 2
) (
  input  logic                       pending,
  input  logic [LVL_W-1:0]           lvl,
  input  logic [(1<<SLOT_W)-1:0]     grp_sel,
  output logic [(1<<(LVL_W-SLOT_W))-1:0] hot
);
  localparam int BIT_W = LVL_W - SLOT_W;
  localparam int BUS_W = 1 << BIT_W;

  logic [SLOT_W-1:0] own_grp;
  logic [BIT_W-1:0]  own_bit;
  logic              in_slot;

  assign own_grp = lvl[LVL_W-1 -: SLOT_W];
  assign own_bit = lvl[BIT_W-1:0];
  assign in_slot = pending & grp_sel[own_grp];

  always_comb begin
    hot = '0;
    for (int k = 0; k < BUS_W; k++) begin
      if (in_slot && own_bit == BIT_W'(k)) hot[k] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_slot_driver.sv
module irq_slot_driver
  import irq_slot_pkg::*;
#(
  parameter int CFG_W   = 16,
  parameter int LVL_W   = 5,
  parameter int SLOT_W  = 2,
  parameter int NUM_SRC = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [SLOT_W-1:0]                  slot_sel,
  input  logic [NUM_SRC-1:0]                 src_flag,
  input  logic [NUM_SRC-1:0]                 src_en,
  input  logic [CFG_W-1:0]                   cfg,
  output logic [(1<<(LVL_W-SLOT_W))-1:0]     irq_bus
);
  localparam int NGRP  = 1 << SLOT_W;
  localparam int BUS_W = 1 << (LVL_W - SLOT_W);

  // Named internal events, visible to the bound checker.
  logic [NUM_SRC-1:0]              pend;
  logic [NGRP-1:0]                 grp_sel;
  logic [NUM_SRC-1:0][LVL_W-1:0]   lvl;
  logic [NUM_SRC-1:0][BUS_W-1:0]   src_hot;
  logic [BUS_W-1:0]                bus_next;

  assign pend = src_flag & src_en;

  irq_cfg_unpack #(.CFG_W(CFG_W), .LVL_W(LVL_W), .NUM_SRC(NUM_SRC)) u_cfg (
    .cfg (cfg),
    .lvl (lvl)
  );

  irq_group_decode #(.SLOT_W(SLOT_W)) u_grp (
    .slot_sel (slot_sel),
    .grp_sel  (grp_sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    irq_src_lane #(.LVL_W(LVL_W), .SLOT_W(SLOT_W)) u_lane (
      .pending (pend[i]),
      .lvl     (lvl[i]),
      .grp_sel (grp_sel),
      .hot     (src_hot[i])
    );
  end

  // Sources share wires without priority: plain OR.
  always_comb begin
    bus_next = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      bus_next = bus_next | src_hot[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_bus <= '0;
    else        irq_bus <= bus_next;
  end
endmodule

// File: rtl/irq_slot_driver_chk.sv
module irq_slot_driver_chk #(
  parameter int LVL_W   = 5,
  parameter int SLOT_W  = 2,
  parameter int NUM_SRC = 2
) (
  input logic                                   clk,
  input logic                                   rst_n,
  input logic [NUM_SRC-1:0]                     pend,
  input logic [(1<<SLOT_W)-1:0]                 grp_sel,
  input logic [NUM_SRC-1:0][(1<<(LVL_W-SLOT_W))-1:0] src_hot,
  input logic [(1<<(LVL_W-SLOT_W))-1:0]         irq_bus
);
  // R1: reset forces an empty bus on the following edge.
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> irq_bus == '0);

  // R3: exactly one level group is active in every cycle.
  a_r3_one_group: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(grp_sel));

  // R5: no pending source means an empty bus one cycle later.
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pend == '0 |=> irq_bus == '0);

  // R7: never more bits than there are sources.
  a_r7_bit_budget: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_bus) <= NUM_SRC);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // R4: a lane drives at most one level.
    a_r4_lane_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_hot[i]));
    // R5: a lane that is not pending is silent.
    a_r5_lane_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !pend[i] |-> src_hot[i] == '0);
  end
endmodule

bind irq_slot_driver irq_slot_driver_chk #(
  .LVL_W(LVL_W), .SLOT_W(SLOT_W), .NUM_SRC(NUM_SRC)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pend    (pend),
  .grp_sel (grp_sel),
  .src_hot (src_hot),
  .irq_bus (irq_bus)
);

// File: tb/sim_irq_slot_driver.sv
`timescale 1ns/1ps
module sim_irq_slot_driver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  slot;
  logic [1:0]  flag;
  logic [1:0]  en;
  logic [15:0] cfg;
  logic [7:0]  bus;

  int nvec = 0;
  int nbad = 0;
  logic [7:0] prev_exp = 8'h00;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_slot_driver u0 (
    .clk(clk), .rst_n(rst_n), .slot_sel(slot), .src_flag(flag),
    .src_en(en), .cfg(cfg), .irq_bus(bus)
  );

  // Slot code to group per the table of R3.
  function automatic int slot_group(input logic [1:0] s);
    case (s)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [1:0] s, input logic [15:0] c,
                                       input logic [1:0] f, input logic [1:0] e);
    logic [7:0] r;
    int l1, l2, g;
    r  = 8'h00;
    g  = slot_group(s);
    l1 = int'(c[15:11]);
    l2 = int'(c[10:6]);
    if (f[0] && e[0] && (l1 / 8) == g) r[l1 % 8] = 1'b1;
    if (f[1] && e[1] && (l2 / 8) == g) r[l2 % 8] = 1'b1;
    return r;
  endfunction

  function automatic logic [15:0] mk_cfg(input int l1, input int l2, input logic [5:0] rs);
    return {5'(l1), 5'(l2), rs};
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Called just after a falling edge: drive, look before the edge, look after it.
  task automatic apply(input string tag, input logic [1:0] s, input logic [1:0] f,
                       input logic [1:0] e, input logic [15:0] c);
    logic [7:0] exp;
    slot = s; flag = f; en = e; cfg = c;
    #2;
    check("R9 bus held until edge", bus, prev_exp);
    @(negedge clk);
    exp = model(s, c, f, e);
    check(tag, bus, exp);
    prev_exp = exp;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    logic [1:0] codes [4];
    logic [15:0] ca, cb;
    codes[0] = 2'b00; codes[1] = 2'b01; codes[2] = 2'b11; codes[3] = 2'b10;
    void'($urandom(32'd20240611));

    // R1: reset with requests present.
    rst_n = 1'b0; slot = 2'b00; flag = 2'b11; en = 2'b11; cfg = mk_cfg(3, 5, 6'd0);
    repeat (3) @(negedge clk);
    check("R1 bus in reset", bus, 8'h00);
    rst_n = 1'b1;
    prev_exp = 8'h00;

    // R2 R3 R4 R6: every level of queue 1, then queue 2, in every slot.
    for (int l = 0; l < 32; l++) begin
      for (int k = 0; k < 4; k++) begin
        apply("R2/R3/R4/R6 queue1 sweep", codes[k], 2'b01, 2'b01, mk_cfg(l, 31 - l, 6'd0));
      end
    end
    for (int l = 0; l < 32; l++) begin
      for (int k = 0; k < 4; k++) begin
        apply("R2/R3/R4/R6 queue2 sweep", codes[k], 2'b10, 2'b10, mk_cfg(31 - l, l, 6'd0));
      end
    end

    // R7: shared level gives one bit (level 19 -> slot 11, bit 3).
    apply("R7 shared level", 2'b11, 2'b11, 2'b11, mk_cfg(19, 19, 6'd0));
    check("R7 shared level single bit", bus, 8'h08);
    // R7: same slot, different levels (9 and 14 in slot 01).
    apply("R7 same slot", 2'b01, 2'b11, 2'b11, mk_cfg(9, 14, 6'd0));
    check("R7 same slot OR", bus, 8'h42);
    // R6/R7: different slots, each seen only in its own slot.
    for (int k = 0; k < 4; k++) begin
      apply("R6/R7 split slots", codes[k], 2'b11, 2'b11, mk_cfg(2, 27, 6'd0));
    end

    // R5: flag without enable, and enable without flag.
    apply("R5 flag only", 2'b00, 2'b11, 2'b00, mk_cfg(4, 6, 6'd0));
    check("R5 flag only quiet", bus, 8'h00);
    apply("R5 enable only", 2'b00, 2'b00, 2'b11, mk_cfg(4, 6, 6'd0));
    check("R5 enable only quiet", bus, 8'h00);
    apply("R5 crossed", 2'b00, 2'b01, 2'b10, mk_cfg(4, 6, 6'd0));
    check("R5 crossed quiet", bus, 8'h00);

    // R8: reserved bits toggled, bus unchanged.
    for (int k = 0; k < 4; k++) begin
      apply("R8 reserved clear", codes[k], 2'b11, 2'b11, mk_cfg(8 * k + 1, 8 * k + 6, 6'h00));
      apply("R8 reserved set", codes[k], 2'b11, 2'b11, mk_cfg(8 * k + 1, 8 * k + 6, 6'h3F));
      check("R8 reserved no effect", bus, 8'h42);
    end

    // R1: reset mid-run clears the bus at once.
    apply("R4 before reset", 2'b10, 2'b01, 2'b01, mk_cfg(31, 0, 6'd0));
    rst_n = 1'b0;
    #1;
    check("R1 asynchronous clear", bus, 8'h00);
    @(negedge clk);
    check("R1 held in reset", bus, 8'h00);
    rst_n = 1'b1;
    prev_exp = 8'h00;

    // Constrained random mix.
    for (int n = 0; n < 3000; n++) begin
      ca = 16'($urandom);
      cb = ($urandom % 4 == 0) ? {ca[15:11], ca[15:11], ca[5:0]} : ca;
      apply("R4/R5/R7 random", codes[$urandom % 4], 2'($urandom), 2'($urandom), cb);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule